// File: doc/BRIEF.md
# Binary Rate Multiplier Pulse Generator

The block spreads a programmable number of single-cycle strobes across a repeating window of sixteen input clock cycles. A four-bit rate word selects how many strobes appear in each window, from none up to fifteen. A free-running chain of four toggle stages counts the window position. Each rate bit owns its own group of window positions, and no two groups share a position. The strobe count per window is therefore the binary value of the rate word, and the strobes are interleaved through the window instead of being packed at its start.

A downstream phase stepper uses the strobe to advance its selection, and the window marker to align itself. The rate word is captured only in the last cycle of each window, so software or control logic may change it at any time without producing a partial window. The outputs also include the divide-by-two, -four, -eight and -sixteen taps of the counting chain.

Top module: `brm_pulse_gen`

## Requirements
- R1: In every window, the number of cycles with `next_pulse` high equals the captured rate word read as an unsigned binary number, with `rate_in[3]` as MSB. For example, 4'b1100 gives 12 strobes and 4'b1111 gives 15.
- R2: `div_taps` reads as the window index 0..15 and counts up by one each cycle, wrapping from 15 to 0. `div_taps[k]` toggles every 2^k cycles, so it is the divide-by-2^(k+1) output.
- R3: `frame_start` is high exactly in the cycles where the window index is 0.
- R4: `rate_in[3]` (weight 8) owns the odd window indices, that is every index with bit 0 set.
- R5: `rate_in[2]` (weight 4) owns indices 2, 6, 10 and 14. `rate_in[1]` (weight 2) owns indices 4 and 12. `rate_in[0]` (weight 1) owns index 8. Index 0 never carries a strobe, and at most one rate bit owns any index.
- R6: The rate word is captured only in the cycle with window index 15, and that value governs the next window. Values driven on `rate_in` at any other index have no effect on the strobes.
- R7: While `rst` is high, `div_taps` is 0, `next_pulse` is 0 and the captured rate word is 0. As a result, the first window after reset carries no strobes, whatever `rate_in` holds.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Input clock; all state changes on its rising edge |
| rst | input | 1 | Synchronous reset, active high |
| rate_in | input | 4 | Rate word; the strobe count for the next window |
| next_pulse | output | 1 | Single-cycle strobe in the owned window positions |
| div_taps | output | 4 | Divider chain taps (/2, /4, /8, /16), LSB is /2 |
| frame_start | output | 1 | High in window index 0 |

## Verification
The properties assume that `rst` is held for at least one rising edge before any check applies. They also assume that the captured rate word is the only path from `rate_in` to the strobes, so the value on `rate_in` between captures is unconstrained. The stimulus changes `rate_in` only at falling edges. In some windows it deliberately drives a different value partway through and then replaces it with the intended value just before the capture cycle, so both the capture timing and the ignored mid-window values are exercised. A reset is also applied in the middle of a window, to confirm that the block recovers into a strobe-free window.

// File: rtl/brm_pkg.sv
package brm_pkg;

    // Number of binary divider stages; the window spans 2**BRM_STAGES cycles.
    localparam int unsigned BRM_STAGES = 4;

    // Strobes produced by the window logic in one cycle.
    typedef struct packed {
        logic fire;   // a rate bit owns this index and is set
        logic wrap;   // last index of the window
    } brm_strobe_t;

    // Owner of a window index: index of the rate bit, or `stages` if none.
    // The lowest set bit p of the index selects rate bit (stages-1-p).
    function automatic int unsigned brm_owner(input int unsigned idx,
                                              input int unsigned stages);
        int unsigned own;
        own = stages;
        for (int unsigned p = 0; p < stages; p++) begin
            if (own == stages && idx[p]) own = stages - 1 - p;
        end
        return own;
    endfunction

endpackage

// File: rtl/brm_div_chain.sv
module brm_div_chain #(
    parameter int unsigned STAGES = brm_pkg::BRM_STAGES
) (
    input  logic              clk,
    input  logic              rst,
    output logic [STAGES-1:0] taps,
    output logic              wrap
);
    // carry[i] is high when every stage below i is at 1; stage i toggles then
    logic [STAGES:0] carry;
    assign carry[0] = 1'b1;

    for (genvar i = 0; i < STAGES; i++) begin : g_stage
        logic q;
        always_ff @(posedge clk) begin
            if (rst)           q <= 1'b0;
            else if (carry[i]) q <= ~q;
        end
        assign taps[i]    = q;
        assign carry[i+1] = carry[i] & q;
    end

    assign wrap = carry[STAGES];
endmodule

// File: rtl/brm_rate_latch.sv
module brm_rate_latch #(
    parameter int unsigned STAGES = brm_pkg::BRM_STAGES
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic [STAGES-1:0] rate_in,
    output logic [STAGES-1:0] rate_q
);
    always_ff @(posedge clk) begin
        if (rst)       rate_q <= '0;
        else if (load) rate_q <= rate_in;
    end
endmodule

// File: rtl/brm_slot_gate.sv
module brm_slot_gate #(
    parameter int unsigned STAGES = brm_pkg::BRM_STAGES
) (
    input  logic [STAGES-1:0] taps,
    input  logic [STAGES-1:0] rate_q,
    output logic [STAGES-1:0] hit,
    output logic              fire
);
    // Rate bit i owns indices whose low (STAGES-i) bits are 1 followed by zeros.
    for (genvar i = 0; i < STAGES; i++) begin : g_slot
        localparam int unsigned M = STAGES - i;
        localparam logic [M-1:0] PAT = M'(1) << (M - 1);
        assign hit[i] = rate_q[i] & (taps[M-1:0] == PAT);
    end

    assign fire = |hit;
endmodule

// File: rtl/brm_pulse_gen.sv
module brm_pulse_gen #(
    parameter int unsigned STAGES = brm_pkg::BRM_STAGES
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [STAGES-1:0] rate_in,
    output logic              next_pulse,
    output logic [STAGES-1:0] div_taps,
    output logic              frame_start
);
    import brm_pkg::*;

    logic [STAGES-1:0] taps;
    logic [STAGES-1:0] rate_q;
    logic [STAGES-1:0] slot_hit;
    brm_strobe_t       strobe;

    brm_div_chain #(.STAGES(STAGES)) u_div (
        .clk  (clk),
        .rst  (rst),
        .taps (taps),
        .wrap (strobe.wrap)
    );

    brm_rate_latch #(.STAGES(STAGES)) u_latch (
        .clk     (clk),
        .rst     (rst),
        .load    (strobe.wrap),
        .rate_in (rate_in),
        .rate_q  (rate_q)
    );

    brm_slot_gate #(.STAGES(STAGES)) u_gate (
        .taps   (taps),
        .rate_q (rate_q),
        .hit    (slot_hit),
        .fire   (strobe.fire)
    );

    assign next_pulse  = strobe.fire;
    assign div_taps    = taps;
    assign frame_start = ~|taps;
endmodule

// File: rtl/brm_pulse_gen_chk.sv
module brm_pulse_gen_chk #(
    parameter int unsigned STAGES = brm_pkg::BRM_STAGES
) (
    input logic              clk,
    input logic              rst,
    input logic [STAGES-1:0] rate_q,
    input logic [STAGES-1:0] taps,
    input logic [STAGES-1:0] hit,
    input logic              next_pulse,
    input logic              frame_start
);
    AST_TAP_ADVANCE: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> taps == STAGES'($past(taps) + 1'b1)); // R2

    AST_WRAP_MARK: assert property (@(posedge clk) disable iff (rst)
        (&taps) |=> frame_start); // R3

    AST_ODD_SLOT: assert property (@(posedge clk) disable iff (rst)
        taps[0] |-> (next_pulse == rate_q[STAGES-1])); // R4

    AST_START_NO_PULSE: assert property (@(posedge clk) disable iff (rst)
        frame_start |-> !next_pulse); // R5

    AST_SLOTS_DISJOINT: assert property (@(posedge clk) disable iff (rst)
        $onehot0(hit)); // R5

    AST_RATE_HOLD: assert property (@(posedge clk) disable iff (rst)
        !(&taps) |=> $stable(rate_q)); // R6
endmodule

bind brm_pulse_gen brm_pulse_gen_chk #(.STAGES(STAGES)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .rate_q      (rate_q),
    .taps        (taps),
    .hit         (slot_hit),
    .next_pulse  (next_pulse),
    .frame_start (frame_start)
);

// File: tb/brm_pulse_gen_bench.sv
module brm_pulse_gen_bench;
    localparam int W = 4;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic [W-1:0] rate_in = '0;
    logic         next_pulse;
    logic [W-1:0] div_taps;
    logic         frame_start;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    brm_pulse_gen u_brm_pulse_gen (
        .clk         (clk),
        .rst         (rst),
        .rate_in     (rate_in),
        .next_pulse  (next_pulse),
        .div_taps    (div_taps),
        .frame_start (frame_start)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Expected strobe at window index j for captured word m.
    function automatic bit exp_pulse(input int j, input logic [W-1:0] m);
        for (int p = 0; p < W; p++) begin
            if (j[p]) return m[W-1-p];
        end
        return 1'b0;
    endfunction

    // Called at the falling edge that shows window index 0; returns at the next one.
    task automatic run_frame(input logic [W-1:0] exp_m, input int junk_at,
                             input logic [W-1:0] junk, input logic [W-1:0] nxt);
        int cnt = 0;
        for (int j = 0; j < 16; j++) begin
            check(div_taps == W'(j), "R2 taps", int'(div_taps), j);
            check(frame_start == (j == 0), "R3 frame_start", int'(frame_start), int'(j == 0));
            if (j[0])
                check(next_pulse == exp_pulse(j, exp_m), "R4 odd slot", int'(next_pulse), int'(exp_pulse(j, exp_m)));
            else
                check(next_pulse == exp_pulse(j, exp_m), "R5 even slot", int'(next_pulse), int'(exp_pulse(j, exp_m)));
            if (next_pulse) cnt++;
            if (j == junk_at) rate_in = junk;
            if (j == 15) rate_in = nxt;
            @(negedge clk);
        end
        check(cnt == int'(exp_m), "R1 count", cnt, int'(exp_m));
    endtask

    initial begin
        #(20 * 200000);
        if (!done) begin
            failures++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        rate_in = 4'b1111;
        repeat (3) @(negedge clk);
        // R7: state held in reset
        check(div_taps == '0, "R7 reset taps", int'(div_taps), 0);
        check(next_pulse == 1'b0, "R7 reset next", int'(next_pulse), 0);
        rst = 1'b0;
        // R7: first window strobe-free even with a full rate word present
        run_frame(4'd0, -1, 4'd0, 4'b1100);
        run_frame(4'b1100, -1, 4'd0, 4'b1111);
        run_frame(4'b1111, -1, 4'd0, 4'd0);
        // R1 sweep over every rate word
        for (int m = 0; m < 16; m++) begin
            run_frame(W'(m == 0 ? 0 : m - 1), -1, 4'd0, W'(m));
        end
        run_frame(4'd15, -1, 4'd0, 4'd5);
        // R6: mid-window values are ignored
        run_frame(4'd5, 3, 4'd15, 4'd9);
        run_frame(4'd9, 0, 4'd0, 4'd6);
        run_frame(4'd6, 14, 4'd15, 4'd6);
        run_frame(4'd6, -1, 4'd0, 4'd10);
        // R7: reset in the middle of a window
        repeat (5) @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        check(div_taps == '0, "R7 mid reset taps", int'(div_taps), 0);
        check(next_pulse == 1'b0, "R7 mid reset next", int'(next_pulse), 0);
        rst = 1'b0;
        run_frame(4'd0, -1, 4'd0, 4'd3);
        run_frame(4'd3, -1, 4'd0, 4'd0);
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule